// File: doc/BRIEF.md
# Two-Stage Expiry Watchdog

This block is a countdown watchdog that gives software one missed service for free. A counter is loaded with a programmed timeout and decrements once for every cycle in which the tick enable is high and the timer is not halted. When the counter underflows for the first time, it reloads and raises an expire flag. The block issues its one-cycle system reset pulse only when the counter underflows a second time and that flag has not been cleared in the meantime. With a timeout of T ticks, the time from the last service to the reset is therefore between about T and 2T.

Software controls the block through a flat register port. The port has a synchronous write strobe with an address and data, and a combinational read path selected by a read address. The registers are a control register holding the halt bit, a status register holding the write-one-to-clear expire flag, a reload strobe address, a timeout register limited to TMR_W bits, and an enable register holding an auto-clear bit. The auto-clear bit stands in for a management handler that clears the flag at every expiry. A read-only count register shows the live counter. A no-reboot input suppresses the reset pulse without changing how the flag behaves. The port has no data stream, so it carries no valid/ready handshake: a write takes effect at the next clock edge and is never stalled.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset the halt bit is 1, the expire flag is 0, the auto-clear bit is 0, the timeout and the count both equal TIMEOUT_INIT, and sys_rst_o is 0.
- R2: While not halted, each cycle with tick_en high decrements the count. A tick taken at count 0 is an underflow, and it reloads the count from the timeout, so one period is timeout+1 ticks. The count reads at address 5 in bits [TMR_W-1:0].
- R3: Bit 11 of the control register (address 0) is the halt bit. While it is 1, ticks are ignored and the count holds.
- R4: An underflow while the expire flag is 0 and auto-clear is off sets the flag (bit 3 of the status register, address 1) and produces no reset.
- R5: Writing the status register with bit 3 set clears the flag, and writing it with bit 3 at 0 leaves the flag unchanged. A clear in the same cycle as an underflow takes effect first, so that underflow only sets the flag again.
- R6: An underflow while the flag is set, with auto-clear off and no clear in that cycle, drives sys_rst_o high for exactly the next cycle, clears the flag and reloads the count.
- R7: Any write to address 2 restarts the count from the timeout. It takes priority over a tick in the same cycle and leaves the flag unchanged.
- R8: A write to the timeout register (address 3) is accepted when the value is at most 2^TMR_W-1. A larger value is rejected and leaves the register unchanged. A new value is used from the next reload or underflow.
- R9: While bit 13 of the enable register (address 4) is 1, every underflow leaves the flag at 0 and no reset is issued.
- R10: When no_reboot is high in the cycle of a second underflow, no reset pulse is issued, but the flag is still cleared and the count is still reloaded.
- R11: rd_data follows rd_addr combinationally. Unused bits, the reload address and unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Countdown tick qualifier |
| no_reboot | input | 1 | Suppresses the system reset pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DATA_W | Register read data |
| sys_rst_o | output | 1 | One-cycle system reset pulse |

## Verification
The bench builds the block with DATA_W=16, TMR_W=6 and TIMEOUT_INIT=3. With the short initial timeout, the first and second expiry stages are each only four ticks apart, so directed runs reach a reset pulse quickly. It also lets the random stream, which mostly programs timeouts below 8, pass through many complete two-stage cycles with clears, reloads and no-reboot mixed in. TMR_W=6 places the accept/reject boundary at 63 and 64, and the random timeout writes cross that boundary often.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd1;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd2;
  localparam logic [ADDR_W-1:0] A_TMO    = 3'd3;
  localparam logic [ADDR_W-1:0] A_ENABLE = 3'd4;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd5;

  localparam int B_EXPIRE  = 3;
  localparam int B_HALT    = 11;
  localparam int B_AUTOCLR = 13;

  typedef enum logic {
    EXP_IDLE  = 1'b0,
    EXP_ARMED = 1'b1
  } exp_state_e;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int TMR_W        = 6,
  parameter int TIMEOUT_INIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [TMR_W-1:0]  cnt_i,
  input  logic              flag_i,
  output logic [DATA_W-1:0] rd_data,
  output logic              halt_o,
  output logic              autoclr_o,
  output logic [TMR_W-1:0]  timeout_o,
  output logic              reload_o,
  output logic              clr_o
);
  localparam logic [TMR_W-1:0] INIT_V = TMR_W'(TIMEOUT_INIT);

  logic             halt_q;
  logic             auto_q;
  logic [TMR_W-1:0] tmo_q;
  logic             tmo_ok;

  // Timeout fits when every bit above the field is zero.
  assign tmo_ok   = (wr_data[DATA_W-1:TMR_W] == '0);
  assign reload_o = wr_en && (wr_addr == A_RELOAD);
  assign clr_o    = wr_en && (wr_addr == A_STATUS) && wr_data[B_EXPIRE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_q <= 1'b1;
      auto_q <= 1'b0;
      tmo_q  <= INIT_V;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:   halt_q <= wr_data[B_HALT];
        A_ENABLE: auto_q <= wr_data[B_AUTOCLR];
        A_TMO:    if (tmo_ok) tmo_q <= wr_data[TMR_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:   rd_data[B_HALT]    = halt_q;
      A_STATUS: rd_data[B_EXPIRE]  = flag_i;
      A_TMO:    rd_data[TMR_W-1:0] = tmo_q;
      A_ENABLE: rd_data[B_AUTOCLR] = auto_q;
      A_COUNT:  rd_data[TMR_W-1:0] = cnt_i;
      default:  rd_data = '0;
    endcase
  end

  assign halt_o    = halt_q;
  assign autoclr_o = auto_q;
  assign timeout_o = tmo_q;

  p_tmo_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_TMO && !tmo_ok) |=> $stable(tmo_q));
  p_tmo_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_TMO && tmo_ok) |=> (tmo_q == $past(wr_data[TMR_W-1:0])));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int TMR_W        = 6,
  parameter int TIMEOUT_INIT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             halt_i,
  input  logic             reload_i,
  input  logic [TMR_W-1:0] timeout_i,
  output logic [TMR_W-1:0] cnt_o,
  output logic             uflow_o
);
  localparam logic [TMR_W-1:0] INIT_V = TMR_W'(TIMEOUT_INIT);

  logic [TMR_W-1:0] cnt_q;
  logic             step;

  assign step    = tick_i && !halt_i && !reload_i;
  assign uflow_o = step && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= INIT_V;
    end else if (reload_i || uflow_o) begin
      cnt_q <= timeout_i;
    end else if (step) begin
      cnt_q <= cnt_q - TMR_W'(1);
    end
  end

  assign cnt_o = cnt_q;

  p_halt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i && !reload_i) |=> $stable(cnt_q));
  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> (cnt_q == $past(timeout_i)));
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    uflow_o |=> (cnt_q == $past(timeout_i)));
endmodule

// File: rtl/wdt_expiry.sv
module wdt_expiry
  import wdt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic uflow_i,
  input  logic clr_i,
  input  logic autoclr_i,
  input  logic no_reboot_i,
  output logic flag_o,
  output logic sys_rst_o
);
  exp_state_e state_q, state_d;
  logic       rst_q, rst_d;

  always_comb begin
    state_d = state_q;
    rst_d   = 1'b0;
    if (uflow_i) begin
      if (autoclr_i) begin
        state_d = EXP_IDLE;
      end else if (state_q == EXP_ARMED && !clr_i) begin
        rst_d   = !no_reboot_i;
        state_d = EXP_IDLE;
      end else begin
        state_d = EXP_ARMED;
      end
    end else if (clr_i) begin
      state_d = EXP_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= EXP_IDLE;
      rst_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rst_q   <= rst_d;
    end
  end

  assign flag_o    = (state_q == EXP_ARMED);
  assign sys_rst_o = rst_q;

  p_pulse_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> !rst_q);
  p_pulse_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow_i && flag_o && !clr_i && !autoclr_i && !no_reboot_i) |=> (rst_q && !flag_o));
  p_first_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow_i && !flag_o) |=> !rst_q);
  p_autoclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow_i && autoclr_i) |=> (!flag_o && !rst_q));
  p_noreboot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow_i && no_reboot_i) |=> !rst_q);
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int TMR_W        = 6,
  parameter int TIMEOUT_INIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              no_reboot,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              sys_rst_o
);
  logic             halt;
  logic             autoclr;
  logic [TMR_W-1:0] timeout;
  logic             reload;
  logic             clr;
  logic [TMR_W-1:0] cnt;
  logic             uflow;
  logic             flag;

  wdt_regs #(
    .DATA_W(DATA_W), .TMR_W(TMR_W), .TIMEOUT_INIT(TIMEOUT_INIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .cnt_i(cnt), .flag_i(flag),
    .rd_data(rd_data), .halt_o(halt), .autoclr_o(autoclr),
    .timeout_o(timeout), .reload_o(reload), .clr_o(clr)
  );

  wdt_counter #(
    .TMR_W(TMR_W), .TIMEOUT_INIT(TIMEOUT_INIT)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .tick_i(tick_en), .halt_i(halt), .reload_i(reload),
    .timeout_i(timeout), .cnt_o(cnt), .uflow_o(uflow)
  );

  wdt_expiry u_exp (
    .clk(clk), .rst_n(rst_n),
    .uflow_i(uflow), .clr_i(clr), .autoclr_i(autoclr),
    .no_reboot_i(no_reboot), .flag_o(flag), .sys_rst_o(sys_rst_o)
  );

  p_reload_keeps_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !clr) |=> $stable(flag));
endmodule

// File: tb/wdt_two_stage_tb_top.sv
module wdt_two_stage_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        no_reboot = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        sys_rst_o;

  int total = 0;
  int fails = 0;
  string ph = "R1";

  // Reference state
  int m_cnt, m_tmo;
  bit m_flag, m_halt, m_auto, m_rst;

  always #5 clk = ~clk;

  wdt_two_stage #(.DATA_W(16), .TMR_W(6), .TIMEOUT_INIT(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .no_reboot(no_reboot),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sys_rst_o(sys_rst_o)
  );

  function automatic logic [15:0] exp_rd(input logic [2:0] a);
    logic [15:0] v = '0;
    case (a)
      3'd0: v[11] = m_halt;
      3'd1: v[3]  = m_flag;
      3'd3: v     = 16'(m_tmo);
      3'd4: v[13] = m_auto;
      3'd5: v     = 16'(m_cnt);
      default: v  = '0;
    endcase
    return v;
  endfunction

  function automatic string atag(input logic [2:0] a);
    case (a)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd3: return "R8";
      3'd4: return "R9";
      3'd5: return "R2";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_step(input bit tk, input bit we, input logic [2:0] wa,
                            input logic [15:0] wd, input bit nr);
    bit reload = we && wa == 3'd2;
    bit clr    = we && wa == 3'd1 && wd[3];
    bit uf     = tk && !m_halt && !reload && m_cnt == 0;
    int nc     = m_cnt;
    if (reload) nc = m_tmo;
    else if (tk && !m_halt) nc = (m_cnt == 0) ? m_tmo : m_cnt - 1;
    m_rst = 1'b0;
    if (uf) begin
      if (m_auto) m_flag = 1'b0;
      else if (m_flag && !clr) begin m_rst = !nr; m_flag = 1'b0; end
      else m_flag = 1'b1;
    end else if (clr) m_flag = 1'b0;
    if (we) begin
      case (wa)
        3'd0: m_halt = wd[11];
        3'd3: if (wd <= 16'd63) m_tmo = int'(wd);
        3'd4: m_auto = wd[13];
        default: ;
      endcase
    end
    m_cnt = nc;
  endtask

  // Drive at the falling edge, let one rising edge pass, compare at the next falling edge.
  task automatic step(input bit tk, input bit we, input logic [2:0] wa,
                      input logic [15:0] wd, input logic [2:0] ra, input bit nr);
    tick_en = tk; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra; no_reboot = nr;
    model_step(tk, we, wa, wd, nr);
    @(posedge clk);
    @(negedge clk);
    check({ph, "/R6"}, {15'd0, sys_rst_o}, {15'd0, m_rst});
    check({ph, "/", atag(ra)}, rd_data, exp_rd(ra));
  endtask

  task automatic ticks(input int n, input logic [2:0] ra, input bit nr);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 3'd0, 16'h0, ra, nr);
  endtask

  task automatic wr(input logic [2:0] wa, input logic [15:0] wd, input logic [2:0] ra);
    step(1'b0, 1'b1, wa, wd, ra, 1'b0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1357));
    m_cnt = 3; m_tmo = 3; m_flag = 0; m_halt = 1; m_auto = 0; m_rst = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values on every address
    ph = "R1";
    for (int a = 0; a < 8; a++) step(1'b0, 1'b0, 3'd0, 16'h0, 3'(a), 1'b0);
    check("R1 count", rd_data, 16'h0000); // last address 7 reads 0
    check("R1 sys_rst_o", {15'd0, sys_rst_o}, 16'h0000);

    // R3: halted at reset, ticks ignored
    ph = "R3";
    ticks(5, 3'd5, 1'b0);
    check("R3 count held while halted", rd_data, 16'h0003);

    // R2/R4: un-halt, count down to first underflow
    ph = "R4";
    wr(3'd0, 16'h0000, 3'd5);
    ticks(3, 3'd5, 1'b0);
    check("R2 count at zero", rd_data, 16'h0000);
    ticks(1, 3'd1, 1'b0);
    check("R4 flag after first underflow", rd_data, 16'h0008);
    check("R4 no reset on first underflow", {15'd0, sys_rst_o}, 16'h0000);

    // R6: second underflow gives one pulse
    ph = "R6";
    ticks(3, 3'd1, 1'b0);
    ticks(1, 3'd1, 1'b0);
    check("R6 reset pulse", {15'd0, sys_rst_o}, 16'h0001);
    check("R6 flag cleared", rd_data, 16'h0000);
    ticks(1, 3'd5, 1'b0);
    check("R6 pulse single cycle", {15'd0, sys_rst_o}, 16'h0000);
    check("R6 counter reloaded then ticked", rd_data, 16'h0002);

    // R5: clear semantics (count is 2 here)
    ph = "R5";
    ticks(3, 3'd1, 1'b0);
    check("R5 flag set", rd_data, 16'h0008);
    wr(3'd1, 16'hFFF7, 3'd1);
    check("R5 write zero to bit 3 keeps flag", rd_data, 16'h0008);
    wr(3'd1, 16'h0008, 3'd1);
    check("R5 write one clears flag", rd_data, 16'h0000);
    // clear racing an underflow: flag set, then clear with the expiring tick
    ticks(4, 3'd1, 1'b0);
    check("R5 flag set again", rd_data, 16'h0008);
    ticks(3, 3'd1, 1'b0);
    step(1'b1, 1'b1, 3'd1, 16'h0008, 3'd1, 1'b0);
    check("R5 clear wins, no reset", {15'd0, sys_rst_o}, 16'h0000);
    check("R5 underflow re-arms flag", rd_data, 16'h0008);

    // R10: no_reboot suppresses pulse, flag still clears
    ph = "R10";
    ticks(4, 3'd1, 1'b1);
    check("R10 no pulse", {15'd0, sys_rst_o}, 16'h0000);
    check("R10 flag cleared", rd_data, 16'h0000);

    // R7: reload restarts and beats a same-cycle tick
    ph = "R7";
    ticks(2, 3'd5, 1'b0);
    step(1'b1, 1'b1, 3'd2, 16'h1234, 3'd5, 1'b0);
    check("R7 reload restarts count", rd_data, 16'h0003);

    // R8: range limit
    ph = "R8";
    wr(3'd3, 16'd64, 3'd3);
    check("R8 64 rejected", rd_data, 16'h0003);
    wr(3'd3, 16'd63, 3'd3);
    check("R8 63 accepted", rd_data, 16'h003F);
    wr(3'd2, 16'h0, 3'd5);
    check("R8 reload uses new timeout", rd_data, 16'h003F);
    wr(3'd3, 16'd2, 3'd3);
    wr(3'd2, 16'h0, 3'd5);

    // R9: auto-clear keeps flag low across many expiries
    ph = "R9";
    wr(3'd1, 16'h0008, 3'd4);
    wr(3'd4, 16'h2000, 3'd4);
    check("R9 enable readback", rd_data, 16'h2000);
    ticks(12, 3'd1, 1'b0);
    check("R9 flag stays clear", rd_data, 16'h0000);
    wr(3'd4, 16'h0000, 3'd4);

    // Random mix
    ph = "RND";
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom % 100);
      bit we = r < 12;
      logic [2:0] wa = 3'($urandom % 8);
      logic [15:0] wd = 16'($urandom);
      if (wa == 3'd3) wd = ($urandom % 6 == 0) ? 16'(60 + $urandom % 8) : 16'($urandom % 8);
      if (wa == 3'd0 && ($urandom % 3 != 0)) wd[11] = 1'b0;
      step(($urandom % 100) < 70, we, wa, wd, 3'($urandom % 8), ($urandom % 5) == 0);
    end

    finish_run();
  end
endmodule